// File: doc/BRIEF.md
# Line-Cycle Synchronized Averaging Window Controller

This block decides how many samples make up each low-rate averaging window, and it marks where each window ends. Downstream accumulators (RMS, power, peak) use the end-of-window pulse to latch their results. When automatic frequency compensation is active, the window length N is worked out from the measured line frequency. Each window then covers a whole number of half line-cycles, which cuts the ripple in the averaged results when the mains frequency drifts.

A sequential restoring divider runs without stopping. Each time it is free, it captures the current frequency and half-cycle count and computes N = floor(SampleRate x (half_cycles / 2) / f_line). The newest valid result waits until the next window boundary and is applied only there. In synchronized mode, each new window also waits for the next voltage-channel zero crossing before it starts counting. When compensation is off, or the frequency cannot be trusted, the block falls back to the programmed fixed sample count and runs windows back to back.

Top module: `linesync_win_ctrl`

## Requirements
- R1: While reset is asserted, `win_len` is 4000, `win_end` is 0 and `div_busy` is 0. After reset, the first window waits for a zero crossing only if synchronized mode is active.
- R2: When synchronized mode is inactive, every window boundary loads `win_len` from `fixed_n`, with a value of 0 used as 1. Windows then follow each other with no gap.
- R3: Synchronized mode is active when `afc_on`, `freq_meas_on` and a valid frequency are all present. `line_freq` is unsigned Hz with 8 fractional bits (Hz x 256). In this mode the boundary loads floor(4000 x `half_cycles` x 128 / `line_freq`). For example, 51 Hz (13056) with 100 half-cycles gives 3921.
- R4: A frequency below 20 Hz (raw value below 5120), including zero, makes synchronized mode inactive, so the fallback of R2 applies.
- R5: `win_len` changes only in the cycle in which `win_end` is high.
- R6: In synchronized mode, after a boundary, sample strobes are ignored until a zero-crossing event arrives. A strobe that arrives in the same cycle as that zero crossing is not counted either. The wait also ends if synchronized mode turns inactive.
- R7: The divider starts whenever it is idle, capturing `line_freq` and `half_cycles`, and then stays busy for 35 cycles. The result is stored on the last busy cycle, and only if the captured frequency was valid. A new division starts on the next cycle, so N follows frequency changes.
- R8: The computed N is clamped to the range 1 to 65535.
- R9: `win_end` is a one-cycle pulse. It follows the clock edge at which the strobe that completes `win_len` counted samples is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe for each input sample |
| zc_evt | input | 1 | Voltage-channel zero-crossing event |
| afc_on | input | 1 | Enables automatic frequency compensation |
| freq_meas_on | input | 1 | Line-frequency measurement is running |
| line_freq | input | 16 | Measured line frequency, Hz x 256 |
| half_cycles | input | 16 | Half line-cycles per window |
| fixed_n | input | 16 | Window length used when not synchronized |
| win_len | output | 16 | Current window length N |
| win_end | output | 1 | End-of-window pulse |
| div_busy | output | 1 | Divider is in progress |

## Verification
A sample strobe or zero crossing sampled at one edge shows up in `win_end` and `win_len` right after that same edge. A frequency or half-cycle change reaches `win_len` only at the first boundary after the 36-cycle division that captured it. The bench keeps a behavioural model that is stepped at every rising edge and compared with all three outputs at the following falling edge. Before each boundary whose value is checked directly, the bench holds off the strobes for at least 80 idle cycles after changing an operand, so that a complete division has finished with the new operands.

// File: rtl/linesync_win_ctrl.sv
module linesync_win_ctrl #(
  parameter int N_W         = 16,
  parameter int FREQ_W      = 16,
  parameter int FRAC        = 8,
  parameter int CYC_W       = 16,
  parameter int SAMPLE_RATE = 4000,
  parameter int MIN_HZ      = 20,
  parameter int DEF_N       = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              zc_evt,
  input  logic              afc_on,
  input  logic              freq_meas_on,
  input  logic [FREQ_W-1:0] line_freq,
  input  logic [CYC_W-1:0]  half_cycles,
  input  logic [N_W-1:0]    fixed_n,
  output logic [N_W-1:0]    win_len,
  output logic              win_end,
  output logic              div_busy
);
  localparam int SR_W   = $clog2(SAMPLE_RATE + 1);
  localparam int Q_W    = SR_W + CYC_W + FRAC - 1;
  localparam int STEP_W = $clog2(Q_W);
  localparam int MIN_F  = MIN_HZ << FRAC;

  logic              freq_ok, sync_on;
  logic [Q_W-1:0]    dividend, quo, q_nx;
  logic [FREQ_W-1:0] rem, den;
  logic [FREQ_W:0]   rem_sh, rem_nx;
  logic              take, op_ok;
  logic [STEP_W-1:0] step;
  logic [N_W-1:0]    q_clamp, n_pend, fb_n, cnt;
  logic              waiting;

  assign freq_ok  = line_freq >= FREQ_W'(MIN_F);
  assign sync_on  = afc_on & freq_meas_on & freq_ok;
  assign dividend = (Q_W'(SAMPLE_RATE) * Q_W'(half_cycles)) << (FRAC - 1);
  assign fb_n     = (fixed_n == '0) ? N_W'(1) : fixed_n;

  // one restoring step per cycle
  assign rem_sh = {rem, quo[Q_W-1]};
  assign take   = rem_sh >= {1'b0, den};
  assign rem_nx = take ? rem_sh - {1'b0, den} : rem_sh;
  assign q_nx   = {quo[Q_W-2:0], take};

  always_comb begin
    if (|q_nx[Q_W-1:N_W])           q_clamp = '1;
    else if (q_nx[N_W-1:0] == '0)   q_clamp = N_W'(1);
    else                            q_clamp = q_nx[N_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_busy <= 1'b0;
      step     <= '0;
      quo      <= '0;
      rem      <= '0;
      den      <= '0;
      op_ok    <= 1'b0;
      n_pend   <= N_W'(DEF_N);
    end else if (!div_busy) begin
      div_busy <= 1'b1;
      step     <= '0;
      quo      <= dividend;
      rem      <= '0;
      den      <= line_freq;
      op_ok    <= freq_ok;
    end else begin
      quo  <= q_nx;
      rem  <= rem_nx[FREQ_W-1:0];
      step <= step + 1'b1;
      if (step == STEP_W'(Q_W - 1)) begin
        div_busy <= 1'b0;
        if (op_ok) n_pend <= q_clamp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len <= N_W'(DEF_N);
      win_end <= 1'b0;
      cnt     <= '0;
      waiting <= 1'b1;
    end else begin
      win_end <= 1'b0;
      if (waiting) begin
        if (zc_evt || !sync_on) waiting <= 1'b0;
      end else if (smp_stb) begin
        if (({1'b0, cnt} + 1'b1) >= {1'b0, win_len}) begin
          win_end <= 1'b1;
          cnt     <= '0;
          win_len <= sync_on ? n_pend : fb_n;
          waiting <= sync_on;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_len_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len != $past(win_len)) |-> win_end);
  p_len_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_len != '0);
  p_end_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> $past(smp_stb));
  p_hold_while_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && $past(waiting)) |-> !win_end);
  p_den_held_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && $past(div_busy)) |-> den == $past(den));
  p_count_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < win_len);
endmodule

// File: tb/linesync_win_ctrl_tb.sv
module linesync_win_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0, zc_evt = 1'b0, afc_on = 1'b0, freq_meas_on = 1'b0;
  logic [15:0] line_freq = '0, half_cycles = '0, fixed_n = 16'd10;
  logic [15:0] win_len;
  logic win_end, div_busy;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  always #2 clk = ~clk;

  linesync_win_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .zc_evt(zc_evt),
    .afc_on(afc_on), .freq_meas_on(freq_meas_on), .line_freq(line_freq),
    .half_cycles(half_cycles), .fixed_n(fixed_n),
    .win_len(win_len), .win_end(win_end), .div_busy(div_busy));

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint calc_n(longint cyc, longint f);
    longint q;
    q = (f == 0) ? 65535 : (4000 * cyc * 128) / f;
    if (q > 65535) q = 65535;
    if (q == 0) q = 1;
    return q;
  endfunction

  // behavioural reference model
  longint m_n, m_pend, m_cnt, m_q;
  int m_left;
  bit m_wait, m_end, m_busy, m_ok, m_sync;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 4000; m_pend = 4000; m_cnt = 0; m_wait = 1; m_end = 0;
      m_busy = 0; m_left = 0; m_ok = 0; m_q = 0;
    end else begin
      m_sync = afc_on && freq_meas_on && (line_freq >= 5120);
      m_end = 0;
      if (m_wait) begin
        if (zc_evt || !m_sync) m_wait = 0;
      end else if (smp_stb) begin
        if (m_cnt + 1 >= m_n) begin
          m_end = 1; m_cnt = 0;
          m_n = m_sync ? m_pend : ((fixed_n == 0) ? 1 : fixed_n);
          m_wait = m_sync;
        end else m_cnt++;
      end
      if (!m_busy) begin
        m_busy = 1; m_left = 35; m_ok = (line_freq >= 5120);
        m_q = calc_n(half_cycles, line_freq);
      end else begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          if (m_ok) m_pend = m_q;
        end
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk({cur_req, " win_len"}, win_len, m_n);
    chk({cur_req, " R9 win_end"}, win_end, m_end);
    chk({cur_req, " R7 div_busy"}, div_busy, m_busy);
  end

  initial forever begin
    repeat (37) @(negedge clk);
    zc_evt = 1'b1;
    @(negedge clk);
    zc_evt = 1'b0;
  end

  task automatic run_until_ends(int k, int gap);
    int seen = 0;
    int ph = 0;
    while (1) begin
      @(negedge clk);
      if (win_end) seen++;
      if (seen >= k) break;
      smp_stb = (ph == 0);
      ph = (ph >= gap) ? 0 : ph + 1;
    end
    smp_stb = 1'b0;
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset win_len", win_len, 4000);
    chk("R1 reset win_end", win_end, 0);
    chk("R1 reset div_busy", div_busy, 0);
    cmp_on = 1;
    rst_n = 1'b1;

    cur_req = "R2";
    run_until_ends(1, 0);
    chk("R2 fallback length", win_len, 10);
    run_until_ends(3, 1);

    cur_req = "R3";
    afc_on = 1; freq_meas_on = 1; half_cycles = 2; line_freq = 16'd12800;
    idle(80);
    run_until_ends(1, 1);
    chk("R3 50Hz length", win_len, 80);
    cur_req = "R6";
    run_until_ends(3, 2);

    cur_req = "R5";
    line_freq = 16'd10240;
    idle(80);
    chk("R5 length held mid-window", win_len, 80);
    cur_req = "R7";
    run_until_ends(2, 1);
    chk("R7 tracks 40Hz", win_len, 100);

    cur_req = "R4";
    line_freq = 16'd4864;
    run_until_ends(1, 1);
    chk("R4 19Hz fallback", win_len, 10);
    line_freq = 16'd0;
    run_until_ends(2, 1);
    chk("R4 zero Hz fallback", win_len, 10);
    cur_req = "R2";
    fixed_n = 16'd0;
    run_until_ends(1, 0);
    chk("R2 zero count used as one", win_len, 1);
    fixed_n = 16'd10;
    run_until_ends(1, 0);

    cur_req = "R8";
    half_cycles = 0; line_freq = 16'd12800;
    idle(80);
    run_until_ends(1, 0);
    chk("R8 low clamp", win_len, 1);
    run_until_ends(3, 0);

    cur_req = "R3";
    half_cycles = 100; line_freq = 16'd13056;
    idle(80);
    run_until_ends(1, 0);
    chk("R3 51Hz example", win_len, 3921);

    cur_req = "R8";
    half_cycles = 16'd60000; line_freq = 16'd5120;
    idle(80);
    run_until_ends(1, 0);
    chk("R8 high clamp", win_len, 65535);
    cur_req = "R2";
    afc_on = 0;
    run_until_ends(1, 0);
    chk("R2 back to fixed", win_len, 10);

    idle(4);
    cmp_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule